// File: doc/BRIEF.md
# Prioritized Multi-Level Interrupt Controller

This block gathers up to 32 interrupt request lines into a pending register and reports the highest priority level that is pending, enabled and above the level the processor is currently running at. Each line is given a priority level at build time through one mask vector per level. Each line is also built as either level-sensitive, so its pending bit tracks the input, or latching, so its pending bit stays set until software clears it. Some lines can be made non-maskable. Those lines ignore the enable register, and the level they sit on can always be delivered.

Software loads an enable register and can set or clear latching pending bits through strobe vectors. The processor supplies its current interrupt level. The block answers with a registered pending level and a request flag, which the processor uses to decide whether to take an interrupt and at what level.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the pending register and the enable register are zero, `lvl_o` is 0 and `irq_o` is low.
- R2: A request line that is high sets its pending bit at the next clock edge. When the line goes low, its bit clears at the next edge only if the line is level-type (its `LEVEL_TYPE` bit is 1). A latching line (bit 0) keeps its bit set.
- R3: The vector used for the search is the pending register ANDed with the OR of the enable register and `NMI_LINES`. Non-maskable lines are therefore seen even when their enable bit is 0.
- R4: The result is the highest level k, from 1 to `N_LVL`, such that the mask of level k (bits `(k-1)*N_LINES` upward in `LVL_MASKS`) overlaps the search vector and k is strictly greater than the threshold.
- R5: The threshold equals `cur_lvl_i`, except that when `cur_lvl_i` is at or above `NMI_LEVEL` it is `NMI_LEVEL-1`. A pending non-maskable line at `NMI_LEVEL` is therefore delivered at any current level.
- R6: `irq_o` is high exactly when `lvl_o` is nonzero. When no level qualifies, `lvl_o` is 0.
- R7: Bits of `req_i` at index `N_LINES` or above have no effect on the pending register or on the outputs.
- R8: The `sw_set_i` and `sw_clr_i` strobes set or clear only latching pending bits. Level-type bits follow their request lines regardless of these strobes.
- R9: If a latching line's request is high in the same cycle as its `sw_clr_i` bit, the pending bit ends up set.
- R10: The outputs are registered. A change on `req_i`, `sw_set_i`, `sw_clr_i` or an enable write reaches `lvl_o` at the second clock edge. A change on `cur_lvl_i` reaches it at the first edge.
- R11: When `en_we_i` is high at a clock edge, the enable register loads `en_wdata_i`. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 32 | Request lines; bits at or above N_LINES are ignored |
| en_we_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | N_LINES | New enable register value |
| sw_set_i | input | N_LINES | Software set strobes for latching pending bits |
| sw_clr_i | input | N_LINES | Software clear strobes for latching pending bits |
| cur_lvl_i | input | LW | Current processor interrupt level |
| lvl_o | output | LW | Highest deliverable pending level, 0 if none |
| irq_o | output | 1 | Interrupt request flag |

## Verification
The bench builds the block with 8 lines and 4 levels, with line i at level (i mod 4)+1. Lines 0 to 3 are level-type and lines 4 to 7 latch. Line 7 is non-maskable, and the non-maskable level is 4, which is also the top level. This size lets the bench sweep all 256 pending patterns against every current level from 0 to 7 under three enable values. That sweep covers the threshold cap at and above level 4, the bypass of the enable register, and every overlap between levels. Directed sequences then cover latching versus level clearing, the software strobes, the clear-versus-request collision, the ignored upper request bits and the exact output latency.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int MAX_LINES = 32;
  localparam int MAX_LVL   = 7;

  // Default level assignment: line i sits on level (i mod n_lvl)+1.
  function automatic logic [MAX_LVL*MAX_LINES-1:0] spread_masks(input int n_lines,
                                                                input int n_lvl);
    logic [MAX_LVL*MAX_LINES-1:0] m;
    m = '0;
    for (int lv = 0; lv < MAX_LVL; lv++) begin
      for (int i = 0; i < MAX_LINES; i++) begin
        if (lv < n_lvl && i < n_lines && (i % n_lvl) == lv) begin
          m[lv*n_lines + i] = 1'b1;
        end
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int                 N_LINES    = 32,
  parameter logic [N_LINES-1:0] LEVEL_TYPE = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] sw_set_i,
  input  logic [N_LINES-1:0] sw_clr_i,
  output logic [N_LINES-1:0] pend_o
);

  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] pend_d;

  for (genvar i = 0; i < N_LINES; i++) begin : g_bit
    if (LEVEL_TYPE[i]) begin : g_level
      // tracks the line, software strobes have no say
      assign pend_d[i] = req_i[i];
    end else begin : g_latch
      // hardware request wins over a software clear
      assign pend_d[i] = req_i[i] | sw_set_i[i] | (pend_q[i] & ~sw_clr_i[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_level_search.sv
module irq_level_search #(
  parameter int                         N_LINES   = 32,
  parameter int                         N_LVL     = 7,
  parameter int                         NMI_LEVEL = 7,
  parameter int                         LW        = 3,
  parameter logic [N_LVL*N_LINES-1:0]   LVL_MASKS = '0
) (
  input  logic [N_LINES-1:0] eff_i,
  input  logic [LW-1:0]      cur_lvl_i,
  output logic [LW-1:0]      best_o
);

  logic [LW-1:0] thr;

  always_comb begin
    if (cur_lvl_i >= LW'(NMI_LEVEL)) begin
      thr = LW'(NMI_LEVEL - 1);
    end else begin
      thr = cur_lvl_i;
    end
  end

  // Walk upward; a later (higher) hit overrides an earlier one.
  always_comb begin
    best_o = '0;
    for (int k = 1; k <= N_LVL; k++) begin
      if ((LW'(k) > thr) && (|(eff_i & LVL_MASKS[(k-1)*N_LINES +: N_LINES]))) begin
        best_o = LW'(k);
      end
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int                       N_LINES    = 32,
  parameter int                       N_LVL      = 7,
  parameter int                       NMI_LEVEL  = 7,
  parameter logic [N_LVL*N_LINES-1:0] LVL_MASKS  =
    irq_prio_pkg::spread_masks(N_LINES, N_LVL),
  parameter logic [N_LINES-1:0]       LEVEL_TYPE = '1,
  parameter logic [N_LINES-1:0]       NMI_LINES  = '0,
  localparam int                      LW         = $clog2(N_LVL + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [31:0]        req_i,
  input  logic               en_we_i,
  input  logic [N_LINES-1:0] en_wdata_i,
  input  logic [N_LINES-1:0] sw_set_i,
  input  logic [N_LINES-1:0] sw_clr_i,
  input  logic [LW-1:0]      cur_lvl_i,
  output logic [LW-1:0]      lvl_o,
  output logic               irq_o
);

  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] en_q;
  logic [N_LINES-1:0] en_d;
  logic [N_LINES-1:0] eff;
  logic [LW-1:0]      best;
  logic [LW-1:0]      lvl_q;
  logic               irq_q;
  logic               unused_req_hi;

  // lines at or above N_LINES are dropped here
  assign unused_req_hi = ^req_i;

  irq_pend_reg #(
    .N_LINES    (N_LINES),
    .LEVEL_TYPE (LEVEL_TYPE)
  ) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i[N_LINES-1:0]),
    .sw_set_i (sw_set_i),
    .sw_clr_i (sw_clr_i),
    .pend_o   (pend_q)
  );

  always_comb begin
    en_d = en_q;
    if (en_we_i) begin
      en_d = en_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else begin
      en_q <= en_d;
    end
  end

  assign eff = pend_q & (en_q | NMI_LINES);

  irq_level_search #(
    .N_LINES   (N_LINES),
    .N_LVL     (N_LVL),
    .NMI_LEVEL (NMI_LEVEL),
    .LW        (LW),
    .LVL_MASKS (LVL_MASKS)
  ) u_search (
    .eff_i     (eff),
    .cur_lvl_i (cur_lvl_i),
    .best_o    (best)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      irq_q <= 1'b0;
    end else begin
      lvl_q <= best;
      irq_q <= (best != '0);
    end
  end

  assign lvl_o = lvl_q;
  assign irq_o = irq_q;

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
  parameter int                       N_LINES    = 32,
  parameter int                       N_LVL      = 7,
  parameter int                       NMI_LEVEL  = 7,
  parameter int                       LW         = 3,
  parameter logic [N_LVL*N_LINES-1:0] LVL_MASKS  = '0,
  parameter logic [N_LINES-1:0]       LEVEL_TYPE = '1,
  parameter logic [N_LINES-1:0]       NMI_LINES  = '0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [31:0]        req_i,
  input logic [LW-1:0]      cur_lvl_i,
  input logic [N_LINES-1:0] pend_i,
  input logic [LW-1:0]      lvl_o,
  input logic               irq_o
);

  localparam logic [N_LINES-1:0] NMI_AT_TOP =
    NMI_LINES & LVL_MASKS[(NMI_LEVEL-1)*N_LINES +: N_LINES];

  // R2
  req_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |->
      ((pend_i & $past(req_i[N_LINES-1:0])) == $past(req_i[N_LINES-1:0])));

  // R8
  level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> ((pend_i & LEVEL_TYPE) == ($past(req_i[N_LINES-1:0]) & LEVEL_TYPE)));

  // R6
  flag_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (lvl_o != '0));

  // R5
  nmi_deliver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && (|($past(pend_i) & NMI_AT_TOP))) |-> (lvl_o >= LW'(NMI_LEVEL)));

  // R4
  above_cur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && (lvl_o != '0) && ($past(cur_lvl_i) < LW'(NMI_LEVEL)))
      |-> (lvl_o > $past(cur_lvl_i)));

  // R4
  level_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_o <= LW'(N_LVL));

endmodule

bind irq_prio_ctrl irq_prio_chk #(
  .N_LINES    (N_LINES),
  .N_LVL      (N_LVL),
  .NMI_LEVEL  (NMI_LEVEL),
  .LW         (LW),
  .LVL_MASKS  (LVL_MASKS),
  .LEVEL_TYPE (LEVEL_TYPE),
  .NMI_LINES  (NMI_LINES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .cur_lvl_i (cur_lvl_i),
  .pend_i    (pend_q),
  .lvl_o     (lvl_o),
  .irq_o     (irq_o)
);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;

  localparam int NL = 8;
  localparam int NV = 4;
  localparam int NMI = 4;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   req = '0;
  logic          en_we = 1'b0;
  logic [NL-1:0] en_wdata = '0;
  logic [NL-1:0] sset = '0;
  logic [NL-1:0] sclr = '0;
  logic [LW-1:0] cur = '0;
  logic [LW-1:0] lvl;
  logic          irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_prio_ctrl #(
    .N_LINES    (NL),
    .N_LVL      (NV),
    .NMI_LEVEL  (NMI),
    .LVL_MASKS  (32'h8844_2211),
    .LEVEL_TYPE (8'h0F),
    .NMI_LINES  (8'h80)
  ) u_irq_prio_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_i      (req),
    .en_we_i    (en_we),
    .en_wdata_i (en_wdata),
    .sw_set_i   (sset),
    .sw_clr_i   (sclr),
    .cur_lvl_i  (cur),
    .lvl_o      (lvl),
    .irq_o      (irq)
  );

  // line i on level (i mod 4)+1, line 7 non-maskable, threshold capped at 3
  function automatic int model_lvl(input logic [7:0] p, input logic [7:0] e, input int c);
    logic [7:0] eff;
    int thr;
    int best;
    eff = p & (e | 8'h80);
    thr = (c >= NMI) ? NMI - 1 : c;
    best = 0;
    for (int lv = 1; lv <= NV; lv++) begin
      for (int i = 0; i < NL; i++) begin
        if ((i % NV) + 1 == lv && eff[i] && lv > thr) best = lv;
      end
    end
    return best;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input int exp);
    checks++;
    if (int'(lvl) != exp || irq != (exp != 0)) begin
      fails++;
      $display("FAIL %s: lvl=%0d irq=%0b expected lvl=%0d irq=%0b", tag, lvl, irq, exp, exp != 0);
    end
  endtask

  task automatic write_en(input logic [NL-1:0] v);
    en_wdata = v;
    en_we = 1'b1;
    step(1);
    en_we = 1'b0;
  endtask

  task automatic wipe();
    req = '0;
    sclr = '1;
    step(1);
    sclr = '0;
    step(2);
  endtask

  initial begin
    logic [7:0] en_set [3];
    en_set[0] = 8'h00;
    en_set[1] = 8'hFF;
    en_set[2] = 8'h5A;
    step(2);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    expect_out("R1 reset", 0);
    cur = 3'd0;
    step(1);
    req = 32'h0000_0001;
    step(2);
    // R1 enable reset to zero: masked line gives nothing
    expect_out("R1 enable reset", 0);
    wipe();

    // R3 R4 R5 R6 R11 sweep
    for (int e = 0; e < 3; e++) begin
      write_en(en_set[e]);
      for (int p = 0; p < 256; p++) begin
        req = {24'h0, 8'(p)};
        step(1);
        for (int c = 0; c < 8; c++) begin
          cur = 3'(c);
          step(2);
          expect_out($sformatf("R4 sweep en=%h p=%h cur=%0d", en_set[e], p, c),
                     model_lvl(8'(p), en_set[e], c));
        end
        wipe();
      end
    end

    write_en(8'hFF);
    cur = 3'd0;
    step(1);

    // R10 latency from request and from current level
    req = 32'h0000_0004;
    step(1);
    expect_out("R10 after one edge", 0);
    step(1);
    expect_out("R10 after two edges", 3);
    cur = 3'd3;
    step(1);
    expect_out("R10 cur one edge", 0);
    cur = 3'd0;
    step(1);
    expect_out("R10 cur back", 3);
    en_wdata = 8'h00;
    en_we = 1'b1;
    step(1);
    en_we = 1'b0;
    expect_out("R11 enable write one edge", 3);
    step(1);
    expect_out("R11 enable write two edges", 0);
    write_en(8'hFF);
    wipe();

    // R2 level-type clears, latching stays
    req = 32'h0000_0002;
    step(1);
    req = '0;
    step(2);
    expect_out("R2 level line dropped", 0);
    req = 32'h0000_0020;
    step(1);
    req = '0;
    step(2);
    expect_out("R2 latch line held", 2);
    sclr = 8'h20;
    step(1);
    sclr = '0;
    step(1);
    expect_out("R8 sw clear latch", 0);

    // R8 strobes ignored on level-type bits
    req = 32'h0000_0001;
    sclr = 8'hFF;
    step(1);
    sclr = '0;
    step(1);
    expect_out("R8 clear ignored on level bit", 1);
    req = '0;
    step(2);
    expect_out("R8 level bit follows line", 0);
    sset = 8'h01;
    step(1);
    sset = '0;
    step(1);
    expect_out("R8 set ignored on level bit", 0);
    sset = 8'h40;
    step(1);
    sset = '0;
    step(1);
    expect_out("R8 set on latch bit", 3);
    wipe();

    // R9 request beats clear
    req = 32'h0000_0010;
    sclr = 8'h10;
    step(1);
    req = '0;
    sclr = '0;
    step(2);
    expect_out("R9 request wins over clear", 1);
    wipe();

    // R7 upper request bits ignored
    req = 32'hFFFF_FF00;
    step(3);
    expect_out("R7 out of range lines", 0);
    req = '0;
    step(2);

    // R5 non-maskable line with enable cleared, high current level
    write_en(8'h00);
    req = 32'h0000_0080;
    cur = 3'd7;
    step(2);
    expect_out("R5 nmi at cur=7", 4);
    cur = 3'd4;
    step(1);
    expect_out("R5 nmi at cur=4", 4);
    req = 32'h0000_0008;
    step(2);
    expect_out("R3 masked line3 with enable off", 4);
    wipe();
    expect_out("R3 masked line3 only", 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule